// File: doc/BRIEF.md
# Scoreboard Issue Controller for Fixed-Latency Floating-Point Units

This block decides when each instruction of an in-order stream may enter a functional unit, read its operands and write its result. It lets independent work overtake stalled work without a pipeline interlock. Five units are tracked. Each is a countdown timer of fixed latency: one integer/load unit, two multipliers, one adder and one divider. For every unit the controller keeps a status record: busy flag, operation, destination, the two source register numbers, the producing unit of each source, and a ready flag per source. It also keeps a table that maps every register to the unit that will write it. The stage each unit's instruction occupies (issue, operand read, execute, result write) is that unit's instruction status.

Instructions arrive on a valid/ready port. `iss_ready` depends only on the controller's state and on `iss_op`/`iss_dst`. It never depends on `iss_valid`. A transfer happens on a rising clock edge where both `iss_valid` and `iss_ready` are high. While `iss_valid` is high without `iss_ready`, the source must hold all issue fields stable. The controller raises a one-cycle `rd_en` bit when a unit reads its operands and a one-cycle `wr_en` bit when a unit writes its result. The unit's destination register is shown on `wr_dst`.

Top module: `fp_scoreboard`

## Requirements
- R1: Opcode encoding is 0 integer/load, 1 add, 2 multiply, 3 divide. Units take bit positions 0 integer, 1 multiplier A, 2 multiplier B, 3 adder, 4 divider in `rd_en`, `wr_en` and `wr_dst` (5 bits per unit, unit u at bits 5u+4..5u). `iss_ready` is low while every unit of the requested class is busy.
- R2: `iss_ready` is low while any active instruction targets `iss_dst`. An instruction to the same destination issues in the cycle after the earlier writer's `wr_en`.
- R3: An instruction with no pending source producer raises its unit's `rd_en` in the cycle after issue, for exactly one cycle.
- R4: A source produced by an active unit holds back `rd_en` until the cycle after that producer's `wr_en`.
- R5: `wr_en` rises L+1 cycles after the unit's `rd_en`, where L is 1 integer, 2 add, 10 multiply, 40 divide. `wr_dst` then shows that unit's destination.
- R6: A unit's `wr_en` is held while another unit still waits to read the same register as a source. The write happens in the cycle after that reader's `rd_en`.
- R7: An instruction that issues in the same cycle as its source producer's `wr_en` treats that source as ready. It raises `rd_en` in the next cycle.
- R8: Several units may raise `wr_en` in one cycle, and later instructions may write before earlier ones.
- R9: After synchronous reset all tables are empty: `iss_ready` is high and `rd_en` and `wr_en` are zero.
- R10: A multiply goes to multiplier A when it is free, otherwise to multiplier B. At most one unit accepts an instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_op | input | 2 | Operation class |
| iss_dst | input | 5 | Destination register |
| iss_src1 | input | 5 | First source register |
| iss_src2 | input | 5 | Second source register |
| rd_en | output | 5 | Per-unit operand read strobe |
| wr_en | output | 5 | Per-unit result write strobe |
| wr_dst | output | 25 | Per-unit destination register, packed |

## Verification
Two kinds of event can land in the same cycle. In the first, a consumer is issued exactly in the cycle its producer writes the source register. The bench times the consumer's issue to that cycle and expects its read strobe on the very next cycle, with no extra wait. In the second, a result write is ready while another unit still waits to read the old value of that register. The bench holds a divide on one slow operand and issues an add that overwrites its other operand. It expects the add's write to be held until the cycle after the divide's read, and checks the exact write cycles of all three instructions.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_ADD = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WRITE = 2'd3
  } stage_e;

  localparam int NUM_FU = 5;
  localparam int U_INT  = 0;
  localparam int U_MULA = 1;
  localparam int U_MULB = 2;
  localparam int U_ADD  = 3;
  localparam int U_DIV  = 4;
  localparam int Q_W    = $clog2(NUM_FU + 1);

  // producer tag: 0 = none, otherwise unit index + 1
  typedef logic [Q_W-1:0] qid_t;

  function automatic logic producer_done(input qid_t q, input logic [NUM_FU-1:0] wb);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (q == Q_W'(i + 1) && wb[i]) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
(
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic              dst_pending,
  input  logic [NUM_FU-1:0] busy,
  output logic              iss_ready,
  output logic [NUM_FU-1:0] grant,
  output qid_t              grant_id
);
  logic [NUM_FU-1:0] pick;

  always_comb begin
    pick = '0;
    case (op_e'(iss_op))
      OP_INT: if (!busy[U_INT]) pick[U_INT] = 1'b1;
      OP_ADD: if (!busy[U_ADD]) pick[U_ADD] = 1'b1;
      OP_MUL: begin
        if (!busy[U_MULA])      pick[U_MULA] = 1'b1;
        else if (!busy[U_MULB]) pick[U_MULB] = 1'b1;
      end
      OP_DIV: if (!busy[U_DIV]) pick[U_DIV] = 1'b1;
      default: pick = '0;
    endcase
    iss_ready = (|pick) && !dst_pending;
    grant     = (iss_valid && iss_ready) ? pick : '0;
    grant_id  = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (pick[i]) grant_id = Q_W'(i + 1);
    end
  end
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat
  import sb_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [REG_W-1:0]  set_reg,
  input  qid_t              set_unit,
  input  logic [NUM_FU-1:0] clr_vec,
  input  logic [REG_W-1:0]  clr_reg [NUM_FU],
  input  logic [REG_W-1:0]  rd_a,
  input  logic [REG_W-1:0]  rd_b,
  input  logic [REG_W-1:0]  rd_d,
  output qid_t              q_a,
  output qid_t              q_b,
  output qid_t              q_d
);
  qid_t tab [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) tab[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_en && set_reg == REG_W'(r)) begin
          tab[r] <= set_unit;
        end else begin
          for (int u = 0; u < NUM_FU; u++) begin
            if (clr_vec[u] && clr_reg[u] == REG_W'(r)) tab[r] <= '0;
          end
        end
      end
    end
  end

  assign q_a = tab[rd_a];
  assign q_b = tab[rd_b];
  assign q_d = tab[rd_d];

  // R2
  no_waw_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> (tab[set_reg] == '0));
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int  REG_W   = 5,
  parameter int  LAT     = 2,
  parameter op_e UNIT_OP = OP_ADD,
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_en,
  input  logic [1:0]        op_in,
  input  logic [REG_W-1:0]  dst_in,
  input  logic [REG_W-1:0]  src1_in,
  input  logic [REG_W-1:0]  src2_in,
  input  qid_t              qj_in,
  input  qid_t              qk_in,
  input  logic              rj_in,
  input  logic              rk_in,
  input  logic [NUM_FU-1:0] wb_vec,
  input  logic              war_hold,
  output logic              busy,
  output logic [REG_W-1:0]  fi,
  output logic [REG_W-1:0]  fj,
  output logic [REG_W-1:0]  fk,
  output logic              rj,
  output logic              rk,
  output logic              rd_en,
  output logic              wr_en
);
  stage_e          stage;
  logic [CW-1:0]   cnt;
  logic [1:0]      op_q;
  qid_t            qj, qk;

  assign busy  = (stage != ST_IDLE);
  assign rd_en = (stage == ST_READ) && rj && rk;
  assign wr_en = (stage == ST_WRITE) && !war_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_IDLE;
      cnt   <= '0;
      op_q  <= '0;
      fi    <= '0;
      fj    <= '0;
      fk    <= '0;
    end else begin
      case (stage)
        ST_IDLE: if (issue_en) begin
          stage <= ST_READ;
          op_q  <= op_in;
          fi    <= dst_in;
          fj    <= src1_in;
          fk    <= src2_in;
        end
        ST_READ: if (rd_en) begin
          stage <= ST_EXEC;
          cnt   <= CW'(LAT - 1);
        end
        ST_EXEC: begin
          if (cnt == '0) stage <= ST_WRITE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_WRITE: if (wr_en) stage <= ST_IDLE;
        default: stage <= ST_IDLE;
      endcase
    end
  end

  // source readiness tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      rj <= 1'b0; rk <= 1'b0; qj <= '0; qk <= '0;
    end else if (issue_en) begin
      rj <= rj_in; rk <= rk_in; qj <= qj_in; qk <= qk_in;
    end else if (rd_en) begin
      rj <= 1'b0; rk <= 1'b0;
    end else begin
      if (producer_done(qj, wb_vec)) begin rj <= 1'b1; qj <= '0; end
      if (producer_done(qk, wb_vec)) begin rk <= 1'b1; qk <= '0; end
    end
  end

  // R1
  issue_to_free_chk: assert property (@(posedge clk) disable iff (rst)
    issue_en |-> !busy);
  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
  // R10
  op_class_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (op_q == UNIT_OP));
endmodule

// File: rtl/fp_scoreboard.sv
module fp_scoreboard
  import sb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iss_valid,
  output logic                    iss_ready,
  input  logic [1:0]              iss_op,
  input  logic [REG_W-1:0]        iss_dst,
  input  logic [REG_W-1:0]        iss_src1,
  input  logic [REG_W-1:0]        iss_src2,
  output logic [NUM_FU-1:0]       rd_en,
  output logic [NUM_FU-1:0]       wr_en,
  output logic [NUM_FU*REG_W-1:0] wr_dst
);
  function automatic int unit_lat(input int u);
    case (u)
      U_INT:           return LAT_INT;
      U_MULA, U_MULB:  return LAT_MUL;
      U_ADD:           return LAT_ADD;
      default:         return LAT_DIV;
    endcase
  endfunction

  function automatic op_e unit_op(input int u);
    case (u)
      U_INT:           return OP_INT;
      U_MULA, U_MULB:  return OP_MUL;
      U_ADD:           return OP_ADD;
      default:         return OP_DIV;
    endcase
  endfunction

  logic [NUM_FU-1:0] busy, grant, war_hold, s_rj, s_rk;
  logic [REG_W-1:0]  s_fi [NUM_FU];
  logic [REG_W-1:0]  s_fj [NUM_FU];
  logic [REG_W-1:0]  s_fk [NUM_FU];
  qid_t              grant_id, q_a, q_b, q_d;
  logic              rj_new, rk_new;
  qid_t              qj_new, qk_new;

  sb_regstat #(.REG_W(REG_W)) u_regstat (
    .clk      (clk),
    .rst      (rst),
    .set_en   (|grant),
    .set_reg  (iss_dst),
    .set_unit (grant_id),
    .clr_vec  (wr_en),
    .clr_reg  (s_fi),
    .rd_a     (iss_src1),
    .rd_b     (iss_src2),
    .rd_d     (iss_dst),
    .q_a      (q_a),
    .q_b      (q_b),
    .q_d      (q_d)
  );

  sb_issue_sel u_sel (
    .iss_valid   (iss_valid),
    .iss_op      (iss_op),
    .dst_pending (q_d != '0),
    .busy        (busy),
    .iss_ready   (iss_ready),
    .grant       (grant),
    .grant_id    (grant_id)
  );

  // a producer writing in the issue cycle counts as already done
  always_comb begin
    rj_new = (q_a == '0) || producer_done(q_a, wr_en);
    rk_new = (q_b == '0) || producer_done(q_b, wr_en);
    qj_new = rj_new ? '0 : q_a;
    qk_new = rk_new ? '0 : q_b;
  end

  // hold a write while another unit still needs the old register value
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_hold[u] = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && ((s_rj[v] && s_fj[v] == s_fi[u]) ||
                       (s_rk[v] && s_fk[v] == s_fi[u])))
          war_hold[u] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    sb_fu_slot #(
      .REG_W   (REG_W),
      .LAT     (unit_lat(g)),
      .UNIT_OP (unit_op(g))
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .issue_en (grant[g]),
      .op_in    (iss_op),
      .dst_in   (iss_dst),
      .src1_in  (iss_src1),
      .src2_in  (iss_src2),
      .qj_in    (qj_new),
      .qk_in    (qk_new),
      .rj_in    (rj_new),
      .rk_in    (rk_new),
      .wb_vec   (wr_en),
      .war_hold (war_hold[g]),
      .busy     (busy[g]),
      .fi       (s_fi[g]),
      .fj       (s_fj[g]),
      .fk       (s_fk[g]),
      .rj       (s_rj[g]),
      .rk       (s_rk[g]),
      .rd_en    (rd_en[g]),
      .wr_en    (wr_en[g])
    );
    assign wr_dst[g*REG_W +: REG_W] = s_fi[g];
  end

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/fp_scoreboard_tb.sv
module fp_scoreboard_tb;
  localparam int RW = 5;
  localparam int NF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [1:0] iss_op = 2'd0;
  logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [NF-1:0] rd_en, wr_en;
  logic [NF*RW-1:0] wr_dst;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { int dst; int cyc; string req; } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_scoreboard u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .rd_en(rd_en), .wr_en(wr_en), .wr_dst(wr_dst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_exp(input int d, input int c, input string req);
    exp_t e;
    e.dst = d; e.cyc = c; e.req = req;
    expq.push_back(e);
  endtask

  // driver: hold the request until accepted, report the issue cycle
  task automatic do_issue(input int op, input int d, input int s1, input int s2,
                          output int icyc);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 2'(op);
    iss_dst = RW'(d); iss_src1 = RW'(s1); iss_src2 = RW'(s2);
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    icyc = cyc;
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic at_cycle(input int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: every write strobe must match an expected item
  always @(negedge clk) begin
    if (!rst) begin
      for (int u = 0; u < NF; u++) begin
        if (wr_en[u]) begin
          int d;
          int idx;
          d = int'(wr_dst[u*RW +: RW]);
          idx = -1;
          for (int k = 0; k < expq.size(); k++) if (idx < 0 && expq[k].dst == d) idx = k;
          if (idx < 0) begin
            check(1'b0, "R5 unexpected write", d, -1);
          end else begin
            check(cyc == expq[idx].cyc, expq[idx].req, cyc, expq[idx].cyc);
            expq.delete(idx);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a, b, c0, c1, c2, m0, m1, m2, w0, w1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check(iss_ready == 1'b1, "R9 ready", int'(iss_ready), 1);
    check(rd_en == '0, "R9 rd_en", int'(rd_en), 0);
    check(wr_en == '0, "R9 wr_en", int'(wr_en), 0);

    // R3 / R5 / R8: independent add and int, same-cycle writes
    do_issue(1, 1, 2, 3, a);
    do_issue(0, 4, 5, 6, b);
    push_exp(1, a + 4, "R5 add latency");
    push_exp(4, b + 3, "R8 int write same cycle");
    at_cycle(b + 1);
    check(rd_en[0] == 1'b1, "R3 int read", int'(rd_en[0]), 1);
    check(rd_en[3] == 1'b0, "R3 add single read", int'(rd_en[3]), 0);
    drain();

    // R4 RAW, R8 out-of-order completion
    do_issue(2, 7, 1, 2, c0);
    push_exp(7, c0 + 12, "R5 mul latency");
    do_issue(1, 8, 7, 1, c1);
    push_exp(8, c0 + 16, "R4 add after mul");
    do_issue(0, 9, 1, 1, c2);
    push_exp(9, c2 + 3, "R8 int overtakes");
    at_cycle(c2 + 1);
    check(rd_en[3] == 1'b0, "R4 add waits", int'(rd_en[3]), 0);
    check(rd_en[1] == 1'b0, "R3 mul read once", int'(rd_en[1]), 0);
    at_cycle(c0 + 13);
    check(rd_en[3] == 1'b1, "R4 add reads", int'(rd_en[3]), 1);
    drain();

    // R1 / R10 structural stall on the two multipliers
    do_issue(2, 10, 1, 2, m0);
    do_issue(2, 11, 1, 2, m1);
    push_exp(10, m0 + 12, "R5 mul A");
    push_exp(11, m1 + 12, "R10 mul B");
    @(negedge clk);
    iss_op = 2'd2; iss_dst = 5'd12; #1;
    check(iss_ready == 1'b0, "R1 muls busy", int'(iss_ready), 0);
    iss_op = 2'd0; #1;
    check(iss_ready == 1'b1, "R1 int free", int'(iss_ready), 1);
    do_issue(2, 12, 1, 2, m2);
    check(m2 == m0 + 13, "R1 mul issue cycle", m2, m0 + 13);
    push_exp(12, m2 + 12, "R5 third mul");
    at_cycle(m2 + 1);
    check(rd_en[1] == 1'b1, "R10 lowest mul", int'(rd_en[1]), 1);
    drain();

    // R2 WAW stall
    do_issue(1, 13, 1, 2, w0);
    push_exp(13, w0 + 4, "R5 add");
    do_issue(0, 13, 1, 2, w1);
    check(w1 == w0 + 5, "R2 WAW issue cycle", w1, w0 + 5);
    push_exp(13, w1 + 3, "R2 second writer");
    drain();

    // R6 WAR hold
    do_issue(2, 14, 1, 2, c0);
    push_exp(14, c0 + 12, "R5 mul");
    do_issue(3, 15, 14, 16, c1);
    push_exp(15, c0 + 54, "R5 div latency");
    do_issue(1, 16, 1, 2, c2);
    push_exp(16, c0 + 14, "R6 add write held");
    at_cycle(c0 + 6);
    check(wr_en[3] == 1'b0, "R6 add held", int'(wr_en[3]), 0);
    at_cycle(c0 + 13);
    check(rd_en[4] == 1'b1, "R4 div reads", int'(rd_en[4]), 1);
    drain();

    // R7 issue in the producer's write cycle
    do_issue(0, 17, 1, 2, a);
    push_exp(17, a + 3, "R5 int");
    repeat (2) @(negedge clk);
    do_issue(1, 18, 17, 1, b);
    check(b == a + 3, "R7 issue cycle", b, a + 3);
    push_exp(18, b + 4, "R7 consumer write");
    at_cycle(b + 1);
    check(rd_en[3] == 1'b1, "R7 read next cycle", int'(rd_en[3]), 1);
    drain();

    check(expq.size() == 0, "R5 leftover", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule